// File: doc/BRIEF.md
# Priority Column-Drain Pixel Readout

This block reads out a matrix of hit pixels and sends only the hits on to the rest of the chip. The default matrix has 32 columns and 40 rows. When a pixel receives a hit pulse, it raises a flag and records the value of a free-running timestamp bus. Empty pixels cost nothing on the output: only pixels that hold a hit ever produce a word.

A small sequencer steps through three phases in a loop:

- **Freeze.** All pending flags are copied into a confirmed set. A hit that arrives after this point waits for the next pass.
- **Column load.** Each column moves its highest-priority confirmed hit into a per-column end cell. The highest-priority hit is the one with the lowest row. That pixel's flag is then cleared.
- **Drain.** The occupied end cells are emptied onto one shared valid/ready stream, lowest column first. Each word carries column, row and timestamp.

The sequencer returns to column load while confirmed hits remain. Otherwise it starts a new freeze. If a hit arrives on a pixel whose flag is still set, the hit is discarded and counted in a saturating counter.

Top module: `pxro_matrix_readout`

## Requirements
- R1: An output word carries the column in bits [18:14], the row in bits [13:8] and the timestamp in bits [7:0]. The timestamp is the value of `ts_i` sampled on the clock edge that accepted the hit. Hit input bit `c*40 + r` belongs to column c, row r.
- R2: A hit that arrives after the freeze phase of the current pass is not confirmed in that pass. It is emitted only after every hit confirmed earlier, even if it has a higher priority.
- R3: Within one column, confirmed hits leave in ascending row order, at most one per column-load round.
- R4: Among the end cells that are full, the lowest column is emitted first. A batch of simultaneous hits therefore leaves in rounds. Each round holds the next-lowest remaining row of every column, in ascending column order.
- R5: Every accepted hit produces exactly one word, and no word appears without a hit.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` stays stable. The stream advances only on a cycle where both are high.
- R7: A hit on a pixel whose flag is still set is dropped. It produces no word and does not overwrite the stored timestamp. It raises `ovf_count` by one, and the counter stops at 15. A hit on a pixel whose flag has been cleared is accepted and does not count.
- R8: After reset, `out_valid` is low and `ovf_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1280 | Per-pixel hit pulses, bit c*40+r |
| ts_i | input | 8 | Free-running timestamp |
| out_valid | output | 1 | Hit word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | 19 | {column, row, timestamp} |
| ovf_count | output | 4 | Saturating count of dropped hits |

## Verification
Several kinds of hit batch are used, and each tells apart a different ordering rule:
- A lone hit checks the field packing.
- Several rows in a single column show whether row priority holds.
- One row spread over scattered columns separates column priority from arrival order.
- A mixed batch, drained under a toggling ready, tells round-by-round interleaving apart from column-by-column emptying.
- Matrix-corner pixels exercise the field extremes.

A second hit sent to a pixel that is still waiting during a stall shows whether the late hit waits for the next freeze. A burst of repeated hits on a held pixel separates dropping from overwriting, and shows whether the counter saturates. A quiet interval with ready held high shows whether zero suppression holds.

// File: rtl/pxro_pkg.sv
package pxro_pkg;

   typedef enum logic [1:0] {
      PH_FREEZE = 2'd0,
      PH_LOAD   = 2'd1,
      PH_DRAIN  = 2'd2
   } phase_e;

endpackage

// File: rtl/pxro_prio_enc.sv
module pxro_prio_enc #(
   parameter int N     = 40,
   parameter int STYLE = 0,
   localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);

   if (N < 2) begin : g_bad_n
      $error("pxro_prio_enc: N must be at least 2");
   end

   assign found_o = |req_i;

   if (STYLE == 0) begin : g_scan
      // descending scan: the last match written is the lowest index
      always_comb begin
         idx_o = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
         end
      end
   end else if (STYLE == 1) begin : g_isolate
      // isolate the lowest set bit, then OR-encode its position
      logic [N-1:0] lowest;
      assign lowest = req_i & (~req_i + N'(1));
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < N; i++) begin
            if (lowest[i]) idx_o = idx_o | IW'(i);
         end
      end
   end else begin : g_bad_style
      $error("pxro_prio_enc: STYLE must be 0 or 1");
   end

endmodule

// File: rtl/pxro_column.sv
module pxro_column #(
   parameter int NROW      = 40,
   parameter int TSW       = 8,
   parameter int ENC_STYLE = 0,
   localparam int RW       = $clog2(NROW),
   localparam int DW       = $clog2(NROW + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NROW-1:0] hit_i,
   input  logic [TSW-1:0]  ts_i,
   input  logic            freeze_i,
   input  logic            load_i,
   input  logic            drain_i,
   output logic            eoc_full_o,
   output logic [RW-1:0]   eoc_row_o,
   output logic [TSW-1:0]  eoc_ts_o,
   output logic            pend_o,
   output logic [DW-1:0]   drop_o
);

   logic [NROW-1:0] flag_q;
   logic [NROW-1:0] conf_q;
   logic [TSW-1:0]  ts_q [NROW];
   logic [NROW-1:0] set_mask;
   logic [NROW-1:0] take_mask;
   logic [NROW-1:0] drop_mask;
   logic            sel_found;
   logic [RW-1:0]   sel_row;
   logic            take;

   pxro_prio_enc #(.N(NROW), .STYLE(ENC_STYLE)) u_row_enc (
      .req_i   (conf_q),
      .found_o (sel_found),
      .idx_o   (sel_row)
   );

   assign take      = load_i && !eoc_full_o && sel_found;
   assign take_mask = take ? (NROW'(1) << sel_row) : '0;
   assign set_mask  = hit_i & ~flag_q;
   assign drop_mask = hit_i & flag_q;
   assign pend_o    = |conf_q;

   always_comb begin
      drop_o = '0;
      for (int r = 0; r < NROW; r++) begin
         drop_o = drop_o + DW'(drop_mask[r]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q <= '0;
         conf_q <= '0;
      end else begin
         flag_q <= (flag_q & ~take_mask) | set_mask;
         if (freeze_i) conf_q <= flag_q;
         else          conf_q <= conf_q & ~take_mask;
      end
   end

   for (genvar r = 0; r < NROW; r++) begin : g_cell
      always_ff @(posedge clk) begin
         if (set_mask[r]) ts_q[r] <= ts_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         eoc_full_o <= 1'b0;
         eoc_row_o  <= '0;
         eoc_ts_o   <= '0;
      end else if (take) begin
         eoc_full_o <= 1'b1;
         eoc_row_o  <= sel_row;
         eoc_ts_o   <= ts_q[sel_row];
      end else if (drain_i) begin
         eoc_full_o <= 1'b0;
      end
   end

endmodule

// File: rtl/pxro_seq.sv
module pxro_seq
   import pxro_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   any_eoc_i,
   input  logic   any_pend_i,
   output phase_e phase_o
);

   phase_e phase_d;

   always_comb begin
      case (phase_o)
         PH_FREEZE: phase_d = PH_LOAD;
         PH_LOAD:   phase_d = PH_DRAIN;
         PH_DRAIN: begin
            if (any_eoc_i)       phase_d = PH_DRAIN;
            else if (any_pend_i) phase_d = PH_LOAD;
            else                 phase_d = PH_FREEZE;
         end
         default:   phase_d = PH_FREEZE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) phase_o <= PH_FREEZE;
      else     phase_o <= phase_d;
   end

endmodule

// File: rtl/pxro_matrix_readout.sv
module pxro_matrix_readout
   import pxro_pkg::*;
#(
   parameter int NCOL      = 32,
   parameter int NROW      = 40,
   parameter int TSW       = 8,
   parameter int OVW       = 4,
   parameter int ENC_STYLE = 0,
   localparam int CW       = $clog2(NCOL),
   localparam int RW       = $clog2(NROW),
   localparam int WW       = CW + RW + TSW
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NCOL*NROW-1:0] hit_i,
   input  logic [TSW-1:0]       ts_i,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [WW-1:0]        out_word,
   output logic [OVW-1:0]       ovf_count
);

   localparam int DW  = $clog2(NROW + 1);
   localparam int SW  = $clog2(NCOL * NROW + 1);
   localparam int EW  = ((SW > OVW) ? SW : OVW) + 1;
   localparam logic [EW-1:0] OVF_MAX = EW'((1 << OVW) - 1);

   if (NCOL < 2 || NROW < 2) begin : g_bad_dim
      $error("pxro_matrix_readout: matrix needs at least 2 columns and 2 rows");
   end
   if (TSW < 1 || OVW < 1) begin : g_bad_width
      $error("pxro_matrix_readout: TSW and OVW must be positive");
   end

   phase_e          phase;
   logic [NCOL-1:0] eoc_full;
   logic [NCOL-1:0] pend;
   logic [NCOL-1:0] drain;
   logic [RW-1:0]   eoc_row [NCOL];
   logic [TSW-1:0]  eoc_ts  [NCOL];
   logic [DW-1:0]   drops   [NCOL];
   logic            col_found;
   logic [CW-1:0]   col_sel;
   logic            accept;
   logic [SW-1:0]   drop_total;
   logic [EW-1:0]   ovf_sum;

   pxro_seq u_seq (
      .clk        (clk),
      .rst        (rst),
      .any_eoc_i  (|eoc_full),
      .any_pend_i (|pend),
      .phase_o    (phase)
   );

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      pxro_column #(.NROW(NROW), .TSW(TSW), .ENC_STYLE(ENC_STYLE)) u_col (
         .clk        (clk),
         .rst        (rst),
         .hit_i      (hit_i[c*NROW +: NROW]),
         .ts_i       (ts_i),
         .freeze_i   (phase == PH_FREEZE),
         .load_i     (phase == PH_LOAD),
         .drain_i    (drain[c]),
         .eoc_full_o (eoc_full[c]),
         .eoc_row_o  (eoc_row[c]),
         .eoc_ts_o   (eoc_ts[c]),
         .pend_o     (pend[c]),
         .drop_o     (drops[c])
      );
      assign drain[c] = accept && (col_sel == CW'(c));
   end

   pxro_prio_enc #(.N(NCOL), .STYLE(ENC_STYLE)) u_col_enc (
      .req_i   (eoc_full),
      .found_o (col_found),
      .idx_o   (col_sel)
   );

   assign out_valid = (phase == PH_DRAIN) && col_found;
   assign out_word  = {col_sel, eoc_row[col_sel], eoc_ts[col_sel]};
   assign accept    = out_valid && out_ready;

   always_comb begin
      drop_total = '0;
      for (int c = 0; c < NCOL; c++) begin
         drop_total = drop_total + SW'(drops[c]);
      end
      ovf_sum = EW'(ovf_count) + EW'(drop_total);
   end

   always_ff @(posedge clk) begin
      if (rst)                   ovf_count <= '0;
      else if (ovf_sum > OVF_MAX) ovf_count <= OVF_MAX[OVW-1:0];
      else                       ovf_count <= ovf_sum[OVW-1:0];
   end

endmodule

// File: rtl/pxro_matrix_readout_chk.sv
module pxro_matrix_readout_chk #(
   parameter int NCOL = 32,
   parameter int NROW = 40,
   parameter int TSW  = 8,
   parameter int OVW  = 4,
   localparam int CW  = $clog2(NCOL),
   localparam int RW  = $clog2(NROW),
   localparam int WW  = CW + RW + TSW
) (
   input logic           clk,
   input logic           rst,
   input logic           out_valid,
   input logic           out_ready,
   input logic [WW-1:0]  out_word,
   input logic [OVW-1:0] ovf_count
);

   localparam logic [OVW-1:0] CNT_TOP = '1;

   logic past_ok;
   logic rst_q;

   always_ff @(posedge clk) begin
      rst_q   <= rst;
      past_ok <= !rst;
   end

   // R6: a stalled word stays offered and unchanged
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_word));

   // R7: counter never goes down outside reset
   p_mono_r7: assert property (@(posedge clk) disable iff (rst)
      past_ok |-> ovf_count >= $past(ovf_count));

   // R7: counter stays at its ceiling
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
      ovf_count == CNT_TOP |=> ovf_count == CNT_TOP);

   // R1: an offered word never names a row outside the matrix
   p_row_range_r1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> int'(out_word[RW+TSW-1:TSW]) < NROW);

   // R8: first cycle after reset is quiet
   always @(posedge clk) begin
      if (!rst && rst_q) begin
         p_reset_r8: assert (!out_valid && ovf_count == '0);
      end
   end

endmodule

bind pxro_matrix_readout pxro_matrix_readout_chk #(
   .NCOL(NCOL), .NROW(NROW), .TSW(TSW), .OVW(OVW)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_word  (out_word),
   .ovf_count (ovf_count)
);

// File: tb/pxro_matrix_readout_tb_top.sv
module pxro_matrix_readout_tb_top;

   localparam int NCOL = 32;
   localparam int NROW = 40;
   localparam int TSW  = 8;
   localparam int OVW  = 4;
   localparam int WW   = 19;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic [NCOL*NROW-1:0] hit_i = '0;
   logic [TSW-1:0]       ts_i = '0;
   logic                 out_ready = 1'b0;
   logic                 out_valid;
   logic [WW-1:0]        out_word;
   logic [OVW-1:0]       ovf_count;

   pxro_matrix_readout dut_i (
      .clk       (clk),
      .rst       (rst),
      .hit_i     (hit_i),
      .ts_i      (ts_i),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_word  (out_word),
      .ovf_count (ovf_count)
   );

   int            checks = 0;
   int            failures = 0;
   int            ready_mode = 0;
   int            rcyc = 0;
   int            valid_seen = 0;
   bit            done = 1'b0;
   logic [WW-1:0] sb [$];
   int            bc [$];
   int            br [$];
   logic          hold_pend = 1'b0;
   logic [WW-1:0] held_word = '0;

   initial forever #5 clk = ~clk;

   initial forever begin
      @(posedge clk);
      ts_i <= ts_i + 1'b1;
   end

   initial forever begin
      @(posedge clk);
      #1;
      rcyc++;
      case (ready_mode)
         0:       out_ready = 1'b0;
         1:       out_ready = 1'b1;
         default: out_ready = (rcyc % 3) != 0;
      endcase
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor
   initial forever begin
      @(negedge clk);
      if (rst) begin
         hold_pend = 1'b0;
      end else begin
         if (hold_pend)
            check(out_valid && out_word == held_word, "R6", "stalled word changed",
                  {out_valid, out_word}, {1'b1, held_word});
         if (out_valid) valid_seen++;
         if (out_valid && out_ready) begin
            if (sb.size() == 0) begin
               check(1'b0, "R5", "word without hit", out_word, 0);
            end else begin
               logic [WW-1:0] exp_w;
               exp_w = sb.pop_front();
               check(out_word == exp_w, "R1/R3/R4", "word order or content", out_word, exp_w);
            end
         end
         hold_pend = out_valid && !out_ready;
         held_word = out_word;
      end
   end

   // one-cycle batch of simultaneous hits; expected order in rounds (R3, R4)
   task automatic fire_batch();
      logic [NROW-1:0] m [NCOL];
      logic [TSW-1:0]  tsv;
      bit              any;
      for (int c = 0; c < NCOL; c++) m[c] = '0;
      @(posedge clk);
      #1;
      tsv = ts_i;
      for (int i = 0; i < bc.size(); i++) begin
         hit_i[bc[i]*NROW + br[i]] = 1'b1;
         m[bc[i]][br[i]] = 1'b1;
      end
      any = 1'b1;
      while (any) begin
         any = 1'b0;
         for (int c = 0; c < NCOL; c++) begin
            if (m[c] != '0) begin
               any = 1'b1;
               for (int r = 0; r < NROW; r++) begin
                  if (m[c][r]) begin
                     sb.push_back({5'(c), 6'(r), tsv});
                     m[c][r] = 1'b0;
                     break;
                  end
               end
            end
         end
      end
      @(posedge clk);
      #1;
      hit_i = '0;
      bc.delete();
      br.delete();
   endtask

   task automatic add_hit(input int c, input int r);
      bc.push_back(c);
      br.push_back(r);
   endtask

   // repeated hits on one pixel in consecutive cycles, no words expected
   task automatic pulse_same(input int c, input int r, input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
         hit_i[c*NROW + r] = 1'b1;
      end
      @(posedge clk);
      #1;
      hit_i = '0;
   endtask

   task automatic drain();
      while (sb.size() != 0) @(posedge clk);
      repeat (12) @(posedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", sb.size(), 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(!out_valid, "R8", "valid in reset", out_valid, 0);
      check(ovf_count == 0, "R8", "counter in reset", ovf_count, 0);
      @(posedge clk);
      #1;
      rst = 1'b0;
      @(negedge clk);
      check(!out_valid && ovf_count == 0, "R8", "state after reset",
            {out_valid, ovf_count}, 0);

      // R1: lone hit
      ready_mode = 1;
      add_hit(7, 13);
      fire_batch();
      drain();

      // R3: one column, several rows, given out of order
      add_hit(3, 39); add_hit(3, 0); add_hit(3, 20);
      fire_batch();
      drain();

      // R4: one row, scattered columns
      add_hit(31, 5); add_hit(0, 5); add_hit(15, 5);
      fire_batch();
      drain();

      // R4 rounds with a toggling ready (R6 stalls)
      ready_mode = 2;
      add_hit(5, 7); add_hit(5, 2); add_hit(5, 30); add_hit(9, 2);
      add_hit(9, 39); add_hit(0, 11); add_hit(31, 0);
      fire_batch();
      drain();

      // R1 field extremes
      ready_mode = 1;
      add_hit(31, 39); add_hit(0, 0); add_hit(31, 0);
      fire_batch();
      drain();

      // R2: late hit on an already moved pixel waits for the next freeze
      ready_mode = 0;
      add_hit(0, 0); add_hit(0, 1);
      fire_batch();
      repeat (10) @(posedge clk);
      add_hit(0, 0);
      fire_batch();
      repeat (4) @(posedge clk);
      ready_mode = 1;
      drain();
      @(negedge clk);
      check(ovf_count == 0, "R7", "re-hit after clear counted as drop", ovf_count, 0);

      // R7: drops while flag held, then saturation
      ready_mode = 0;
      add_hit(2, 4); add_hit(2, 5);
      fire_batch();
      repeat (6) @(posedge clk);
      pulse_same(2, 5, 3);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(ovf_count == 3, "R7", "drop count", ovf_count, 3);
      pulse_same(2, 5, 17);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(ovf_count == 15, "R7", "saturated drop count", ovf_count, 15);
      ready_mode = 1;
      drain();
      @(negedge clk);
      check(ovf_count == 15, "R7", "counter held at ceiling", ovf_count, 15);

      // R5: quiet matrix yields nothing
      valid_seen = 0;
      repeat (60) @(posedge clk);
      @(negedge clk);
      check(valid_seen == 0, "R5", "words with no hits", valid_seen, 0);
      check(sb.size() == 0, "R5", "words missing", sb.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule